// File: doc/BRIEF.md
# Row-Level Flash Access Guard

This block sits between the bus masters and a row-organised nonvolatile program memory. Each row is 256 bytes of program or data plus 32 bytes of side-band space. The block stores a two-bit protection level for every row. It classifies each request by where it comes from (an external debug or programming port, or an internal bus master) and by whether it is a read or a write. It then passes the request to the memory or blocks it. When it blocks a request, it reports which row was involved.

There are four levels, and they treat the two origins differently. The most open level lets every access through. The next level hides the contents from the outside but still accepts external writes. The third level admits only internal traffic. The strictest level admits nothing except internal reads. Levels cannot be rewritten freely. A whole-array erase wipes the data, returns every row to the open level and opens a load window. Level writes are accepted only while that window is open. An explicit lock command closes it.

Top module: `flashprot_guard`

## Requirements
- R1: At level code 2'b00 (open), all four access types are granted: external read, external write, internal read and internal write.
- R2: At level code 2'b01, external reads are blocked. External writes and internal reads and writes are granted.
- R3: At level code 2'b10, every external access is blocked and every internal access is granted.
- R4: At level code 2'b11, only internal reads are granted. External reads, external writes and internal writes are blocked.
- R5: A blocked read asserts no memory read enable, and its returned data is all zeros in the cycle where read data appears, one clock after the request with the default latency. A granted read returns the stored word in that cycle.
- R6: A blocked write never asserts the memory write enable, and the stored word is left unchanged.
- R7: A blocked access raises `viol_pulse` for the single following cycle and loads `viol_row` with that access's row. It also sets `viol_sticky`, which stays set until the next erase.
- R8: A level write while the load window is closed is ignored, and the row keeps its previous level.
- R9: An erase request gives a one-cycle `mem_erase` pulse on the next cycle. At the same edge it sets every row to level 2'b00, opens the load window and clears `viol_sticky`.
- R10: A lock request closes the load window on the next cycle. If erase and lock arrive in the same cycle, the erase wins and the window opens.
- R11: After reset, the load window is closed, no violation is flagged and every row is at level 2'b00.
- R12: A level write updates only the addressed row, and it takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request present |
| acc_ext | input | 1 | 1 = external port origin, 0 = internal master |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_row | input | ROW_W | Row index of the access |
| acc_wdata | input | DATA_W | Write data |
| acc_grant | output | 1 | Access allowed this cycle |
| acc_rdata | output | DATA_W | Read data, zeroed unless a granted read |
| mem_rd_en | output | 1 | Read enable to the memory array |
| mem_wr_en | output | 1 | Write enable to the memory array |
| mem_row | output | ROW_W | Row index to the memory array |
| mem_wdata | output | DATA_W | Write data to the memory array |
| mem_rdata | input | DATA_W | Read data from the memory array, RD_LAT cycles after the enable |
| mem_erase | output | 1 | Whole-array erase strobe |
| erase_req | input | 1 | Whole-array erase command |
| lock_req | input | 1 | Close the level-load window |
| lvl_wr | input | 1 | Level write strobe |
| lvl_row | input | ROW_W | Row whose level is written |
| lvl_val | input | 2 | New level code |
| window_open | output | 1 | Level-load window is open |
| viol_pulse | output | 1 | One-cycle violation strobe |
| viol_sticky | output | 1 | A violation has occurred since the last erase |
| viol_row | output | ROW_W | Row of the latest violation |

## Verification
The main function is tried on every combination of origin and kind against rows held at each of the four levels. This separates decode faults that swap the origin bit, swap the kind bit or confuse two adjacent level codes. Other rows are left at the open level beside the protected ones, which shows that a level write reaches only the row it addresses. Level writes are issued before an erase, inside the window and after the lock. Each is then judged by an external write that is granted only at the levels that permit it, so an ignored level write is told apart from an accepted one. Erase and lock are also issued in the same cycle to check which command wins.

// File: rtl/flashprot_pkg.sv
package flashprot_pkg;
   typedef enum logic [1:0] {
      LVL_OPEN    = 2'b00,
      LVL_FACTORY = 2'b01,
      LVL_FIELD   = 2'b10,
      LVL_SEALED  = 2'b11
   } prot_lvl_t;
endpackage

// File: rtl/flashprot_level_store.sv
module flashprot_level_store
   import flashprot_pkg::*;
#(
   parameter int NUM_ROWS = 16,
   localparam int ROW_W = $clog2(NUM_ROWS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear_all,
   input  logic                  load_en,
   input  logic [ROW_W-1:0]      load_row,
   input  prot_lvl_t             load_val,
   input  logic [ROW_W-1:0]      rd_row,
   output prot_lvl_t             rd_lvl,
   output logic [2*NUM_ROWS-1:0] lvl_flat
);
   prot_lvl_t lvl_q [NUM_ROWS];

   for (genvar gi = 0; gi < NUM_ROWS; gi++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lvl_q[gi] <= LVL_OPEN;
         else if (clear_all)
            lvl_q[gi] <= LVL_OPEN;
         else if (load_en && load_row == ROW_W'(gi))
            lvl_q[gi] <= load_val;
      end
      assign lvl_flat[2*gi +: 2] = lvl_q[gi];
   end

   assign rd_lvl = lvl_q[rd_row];
endmodule

// File: rtl/flashprot_perm_decode.sv
module flashprot_perm_decode
   import flashprot_pkg::*;
(
   input  prot_lvl_t lvl,
   input  logic      is_ext,
   input  logic      is_wr,
   output logic      allow
);
   always_comb begin
      unique case (lvl)
         LVL_OPEN:    allow = 1'b1;
         LVL_FACTORY: allow = is_wr || !is_ext;
         LVL_FIELD:   allow = !is_ext;
         LVL_SEALED:  allow = !is_ext && !is_wr;
         default:     allow = 1'b0;
      endcase
   end
endmodule

// File: rtl/flashprot_window_ctrl.sv
module flashprot_window_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic erase_req,
   input  logic lock_req,
   input  logic lvl_wr,
   output logic window_open,
   output logic load_en,
   output logic clear_all,
   output logic mem_erase
);
   logic win_q, erase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q   <= 1'b0;
         erase_q <= 1'b0;
      end else begin
         erase_q <= erase_req;
         if (erase_req)
            win_q <= 1'b1;
         else if (lock_req)
            win_q <= 1'b0;
      end
   end

   assign window_open = win_q;
   assign clear_all   = erase_req;
   assign load_en     = lvl_wr && win_q && !erase_req;
   assign mem_erase   = erase_q;
endmodule

// File: rtl/flashprot_rdata_mask.sv
module flashprot_rdata_mask #(
   parameter int DATA_W = 32,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_pass,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rdata
);
   if (RD_LAT == 0) begin : g_comb
      assign rdata = rd_pass ? mem_rdata : '0;
   end else begin : g_pipe
      logic [RD_LAT-1:0] pass_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pass_q <= '0;
         else begin
            pass_q[0] <= rd_pass;
            for (int i = 1; i < RD_LAT; i++)
               pass_q[i] <= pass_q[i-1];
         end
      end
      assign rdata = pass_q[RD_LAT-1] ? mem_rdata : '0;
   end
endmodule

// File: rtl/flashprot_viol_track.sv
module flashprot_viol_track #(
   parameter int ROW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blocked,
   input  logic [ROW_W-1:0] row,
   input  logic             clear,
   output logic             viol_pulse,
   output logic             viol_sticky,
   output logic [ROW_W-1:0] viol_row
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_pulse  <= 1'b0;
         viol_sticky <= 1'b0;
         viol_row    <= '0;
      end else begin
         viol_pulse <= blocked;
         if (blocked)
            viol_row <= row;
         if (clear)
            viol_sticky <= 1'b0;
         else if (blocked)
            viol_sticky <= 1'b1;
      end
   end
endmodule

// File: rtl/flashprot_guard.sv
module flashprot_guard
   import flashprot_pkg::*;
#(
   parameter int NUM_ROWS = 16,
   parameter int DATA_W   = 32,
   parameter int RD_LAT   = 1,
   localparam int ROW_W   = $clog2(NUM_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_ext,
   input  logic              acc_write,
   input  logic [ROW_W-1:0]  acc_row,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              acc_grant,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ROW_W-1:0]  mem_row,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_erase,
   input  logic              erase_req,
   input  logic              lock_req,
   input  logic              lvl_wr,
   input  logic [ROW_W-1:0]  lvl_row,
   input  logic [1:0]        lvl_val,
   output logic              window_open,
   output logic              viol_pulse,
   output logic              viol_sticky,
   output logic [ROW_W-1:0]  viol_row
);
   if (NUM_ROWS < 2 || (NUM_ROWS & (NUM_ROWS - 1)) != 0) begin : g_bad_rows
      $error("NUM_ROWS must be a power of two of at least 2");
   end
   if (RD_LAT < 0 || RD_LAT > 8) begin : g_bad_lat
      $error("RD_LAT must lie in 0..8");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end

   logic                  load_en, clear_all, allow, blocked;
   prot_lvl_t             cur_lvl;
   logic [2*NUM_ROWS-1:0] lvl_flat;

   flashprot_window_ctrl u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .erase_req   (erase_req),
      .lock_req    (lock_req),
      .lvl_wr      (lvl_wr),
      .window_open (window_open),
      .load_en     (load_en),
      .clear_all   (clear_all),
      .mem_erase   (mem_erase)
   );

   flashprot_level_store #(.NUM_ROWS(NUM_ROWS)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_all (clear_all),
      .load_en   (load_en),
      .load_row  (lvl_row),
      .load_val  (prot_lvl_t'(lvl_val)),
      .rd_row    (acc_row),
      .rd_lvl    (cur_lvl),
      .lvl_flat  (lvl_flat)
   );

   flashprot_perm_decode u_perm (
      .lvl    (cur_lvl),
      .is_ext (acc_ext),
      .is_wr  (acc_write),
      .allow  (allow)
   );

   assign acc_grant = acc_valid && allow;
   assign blocked   = acc_valid && !allow;
   assign mem_rd_en = acc_grant && !acc_write;
   assign mem_wr_en = acc_grant && acc_write;
   assign mem_row   = acc_row;
   assign mem_wdata = acc_wdata;

   flashprot_rdata_mask #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_pass   (mem_rd_en),
      .mem_rdata (mem_rdata),
      .rdata     (acc_rdata)
   );

   flashprot_viol_track #(.ROW_W(ROW_W)) u_viol (
      .clk         (clk),
      .rst_n       (rst_n),
      .blocked     (blocked),
      .row         (acc_row),
      .clear       (clear_all),
      .viol_pulse  (viol_pulse),
      .viol_sticky (viol_sticky),
      .viol_row    (viol_row)
   );
endmodule

// File: rtl/flashprot_guard_chk.sv
module flashprot_guard_chk #(
   parameter int NUM_ROWS = 16,
   localparam int ROW_W   = $clog2(NUM_ROWS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  acc_valid,
   input logic                  acc_ext,
   input logic                  acc_write,
   input logic [ROW_W-1:0]      acc_row,
   input logic                  acc_grant,
   input logic                  mem_wr_en,
   input logic [1:0]            cur_lvl,
   input logic [2*NUM_ROWS-1:0] lvl_flat,
   input logic                  erase_req,
   input logic                  lock_req,
   input logic                  window_open,
   input logic                  mem_erase,
   input logic                  viol_pulse,
   input logic                  viol_sticky,
   input logic [ROW_W-1:0]      viol_row
);
   a_r1_open_grants_all: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && cur_lvl == 2'b00 |-> acc_grant);

   a_r2_factory_hides_reads: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && cur_lvl == 2'b01 && acc_ext && !acc_write |-> !acc_grant);

   a_r3_field_no_external: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && cur_lvl == 2'b10 && acc_ext |-> !acc_grant);

   a_r4_sealed_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && cur_lvl == 2'b11 && (acc_ext || acc_write) |-> !acc_grant);

   a_r6_write_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> acc_grant && acc_write);

   a_r7_pulse_and_row: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_grant |=> viol_pulse && viol_row == $past(acc_row));

   a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      viol_sticky && !erase_req |=> viol_sticky);

   a_r8_levels_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !window_open && !erase_req |=> $stable(lvl_flat));

   a_r9_erase_effects: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> window_open && mem_erase && lvl_flat == '0 && !viol_sticky);

   a_r10_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
      lock_req && !erase_req |=> !window_open);
endmodule

bind flashprot_guard flashprot_guard_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid   (acc_valid),
   .acc_ext     (acc_ext),
   .acc_write   (acc_write),
   .acc_row     (acc_row),
   .acc_grant   (acc_grant),
   .mem_wr_en   (mem_wr_en),
   .cur_lvl     (cur_lvl),
   .lvl_flat    (lvl_flat),
   .erase_req   (erase_req),
   .lock_req    (lock_req),
   .window_open (window_open),
   .mem_erase   (mem_erase),
   .viol_pulse  (viol_pulse),
   .viol_sticky (viol_sticky),
   .viol_row    (viol_row)
);

// File: tb/flashprot_guard_bench.sv
module flashprot_guard_bench;
   localparam int NR = 16;
   localparam int DW = 32;
   localparam int RW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 0, acc_ext = 0, acc_write = 0;
   logic [RW-1:0] acc_row = '0;
   logic [DW-1:0] acc_wdata = '0;
   logic          acc_grant;
   logic [DW-1:0] acc_rdata;
   logic          mem_rd_en, mem_wr_en, mem_erase;
   logic [RW-1:0] mem_row;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          erase_req = 0, lock_req = 0, lvl_wr = 0;
   logic [RW-1:0] lvl_row = '0;
   logic [1:0]    lvl_val = '0;
   logic          window_open, viol_pulse, viol_sticky;
   logic [RW-1:0] viol_row;

   always #4 clk = ~clk;

   flashprot_guard #(.NUM_ROWS(NR), .DATA_W(DW), .RD_LAT(1)) u_flashprot_guard (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_ext(acc_ext), .acc_write(acc_write),
      .acc_row(acc_row), .acc_wdata(acc_wdata),
      .acc_grant(acc_grant), .acc_rdata(acc_rdata),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_row(mem_row),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_erase(mem_erase),
      .erase_req(erase_req), .lock_req(lock_req), .lvl_wr(lvl_wr),
      .lvl_row(lvl_row), .lvl_val(lvl_val), .window_open(window_open),
      .viol_pulse(viol_pulse), .viol_sticky(viol_sticky), .viol_row(viol_row)
   );

   // memory array model: one-cycle read latency, data always driven
   logic [DW-1:0] arr [NR];
   initial for (int i = 0; i < NR; i++) arr[i] = '0;
   always @(posedge clk) begin
      mem_rdata <= arr[mem_row];
      if (mem_wr_en) arr[mem_row] <= mem_wdata;
      if (mem_erase) for (int i = 0; i < NR; i++) arr[i] <= '0;
   end

   // bench-side expectations
   logic [1:0]    exp_lvl [NR];
   logic [DW-1:0] exp_mem [NR];
   bit            exp_win = 0, exp_sticky = 0;
   int            n_chk = 0, n_fail = 0;
   bit            done = 0;

   function automatic bit allowed(input logic [1:0] l, input bit ext, input bit wr);
      case (l)
         2'b00:   return 1;
         2'b01:   return !(ext && !wr);
         2'b10:   return !ext;
         default: return !ext && !wr;
      endcase
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic access(input bit ext, input bit wr, input int row,
                         input logic [DW-1:0] wd, input string tag);
      bit ok;
      ok = allowed(exp_lvl[row], ext, wr);
      @(negedge clk);
      acc_valid = 1; acc_ext = ext; acc_write = wr;
      acc_row = RW'(row); acc_wdata = wd;
      #1;
      check({tag, " grant"}, DW'(acc_grant), DW'(ok));
      if (wr) check({tag, " R6 wr_en"}, DW'(mem_wr_en), DW'(ok));
      else    check({tag, " R5 rd_en"}, DW'(mem_rd_en), DW'(ok));
      @(negedge clk);
      acc_valid = 0;
      if (!ok) exp_sticky = 1;
      check({tag, " R7 pulse"}, DW'(viol_pulse), DW'(!ok));
      if (!ok) check({tag, " R7 row"}, DW'(viol_row), DW'(row));
      check({tag, " R7 sticky"}, DW'(viol_sticky), DW'(exp_sticky));
      if (!wr) check({tag, " R5 rdata"}, acc_rdata, ok ? exp_mem[row] : '0);
      if (wr && ok) exp_mem[row] = wd;
   endtask

   task automatic set_level(input int row, input logic [1:0] v);
      @(negedge clk);
      lvl_wr = 1; lvl_row = RW'(row); lvl_val = v;
      @(negedge clk);
      lvl_wr = 0;
      if (exp_win) exp_lvl[row] = v;
   endtask

   task automatic do_erase(input bit with_lock);
      @(negedge clk);
      erase_req = 1; lock_req = with_lock;
      @(negedge clk);
      erase_req = 0; lock_req = 0;
      exp_win = 1; exp_sticky = 0;
      for (int i = 0; i < NR; i++) begin exp_lvl[i] = 2'b00; exp_mem[i] = '0; end
      check("R9 mem_erase pulse", DW'(mem_erase), 1);
      check("R9/R10 window open", DW'(window_open), 1);
      check("R9 sticky cleared", DW'(viol_sticky), 0);
      @(negedge clk);
      check("R9 erase one cycle", DW'(mem_erase), 0);
   endtask

   task automatic do_lock();
      @(negedge clk);
      lock_req = 1;
      @(negedge clk);
      lock_req = 0;
      exp_win = 0;
      check("R10 window closed", DW'(window_open), 0);
   endtask

   task automatic t_reset();
      check("R11 window closed", DW'(window_open), 0);
      check("R11 no pulse", DW'(viol_pulse), 0);
      check("R11 no sticky", DW'(viol_sticky), 0);
      check("R11 no erase", DW'(mem_erase), 0);
   endtask

   task automatic t_open_rows();
      access(1, 1, 3, 32'hA5A5_0003, "R11 R1 ext write");
      access(1, 0, 3, 0, "R1 ext read");
      access(0, 1, 3, 32'h1234_5678, "R1 int write");
      access(0, 0, 3, 0, "R1 int read");
   endtask

   task automatic t_closed_ignored();
      set_level(5, 2'b11);
      access(1, 1, 5, 32'h5555_0005, "R8 ext write after closed load");
      access(1, 0, 5, 0, "R8 ext read after closed load");
   endtask

   task automatic t_erase_and_levels();
      do_erase(0);
      access(0, 0, 3, 0, "R9 data cleared");
      for (int r = 0; r < 5; r++) access(0, 1, r, 32'hD000_0000 + r, "R12 preload");
      set_level(1, 2'b01);
      set_level(2, 2'b10);
      set_level(4, 2'b11);
      do_lock();
      set_level(1, 2'b11);
      access(1, 1, 1, 32'hBEEF_0001, "R8 level after lock ignored");
   endtask

   task automatic t_matrix();
      for (int r = 0; r < 5; r++) begin
         access(1, 0, r, 0, r == 1 ? "R2 ext read" : r == 2 ? "R3 ext read" : r == 4 ? "R4 ext read" : "R12 ext read");
         access(1, 1, r, 32'hE100_0000 + r, r == 1 ? "R2 ext write" : r == 2 ? "R3 ext write" : r == 4 ? "R4 ext write" : "R12 ext write");
         access(0, 1, r, 32'hF200_0000 + r, r == 4 ? "R4 int write R6" : "R12 int write");
         access(0, 0, r, 0, r == 4 ? "R4 int read" : "R12 int read");
      end
   endtask

   task automatic t_sticky_and_clear();
      access(0, 0, 0, 0, "R7 sticky holds");
      do_erase(1);
      access(1, 0, 4, 0, "R9 level reopened");
   endtask

   initial begin
      for (int i = 0; i < NR; i++) begin exp_lvl[i] = 2'b00; exp_mem[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_open_rows();
      t_closed_ignored();
      t_erase_and_levels();
      t_matrix();
      t_sticky_and_clear();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule